// File: doc/BRIEF.md
# Snoop Window Block Mapper

This unit lets a host inspect and patch frame data where it already sits in the shared queue memory. A fixed window of 256 host addresses, 0x300 to 0x3FF, is relocated onto one block of that memory. A block-select register held inside the unit chooses the block. The host typically copies a queue's first-block pointer into that register, and the window then exposes the start of the oldest frame in that queue.

Window reads and writes become plain memory reads and writes at the address `{block pointer, host address[7:0]}`. The unit has no path to the queue head, tail or occupancy state, so accessing frame data through the window leaves the queue exactly as it was. The block-select register sits at host address 0x2F0 and can be read back. The unit does not claim any other host address.

Top module: `snoop_window_map`

## Requirements
- R1: After reset the block pointer is 0, `host_ready` is low, and a read of the block-select register returns 0.
- R2: Only addresses 0x300–0x3FF and 0x2F0 assert `host_claim`. Any access to another address produces no memory strobe and no `host_ready`, and `host_rdata` stays 0.
- R3: During a window access, `mem_addr` equals the block pointer concatenated with host address bits 7:0.
- R4: A window read asserts `mem_re` in the same cycle. In the following cycle `host_ready` is high and `host_rdata` carries the memory word.
- R5: A window write asserts `mem_we` in the same cycle with `mem_wdata` equal to `host_wdata`. `host_ready` follows one cycle later, and the word lands at the physical address given by R3.
- R6: A write to 0x2F0 loads the low PTR_W bits of `host_wdata` into the block pointer. A read of 0x2F0 returns the pointer zero-extended, with `host_ready`, one cycle later.
- R7: A new block pointer is used by the next window access, including one issued in the cycle directly after the register write.
- R8: If `host_rd` and `host_wr` are asserted together, the write is performed and the read is ignored. `mem_re` and `mem_we` are never high together.
- R9: Accesses to the block-select register never strobe the memory, and window accesses never change the block pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 12 | Host byte-free word address |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_ready | output | 1 | Completion of a claimed access, one cycle after the strobe |
| host_claim | output | 1 | Current address belongs to this unit |
| mem_addr | output | 12 | Physical queue memory word address |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_re |

## Verification
The hardest case to reach from the ports is the relocation race: a block-select write followed in the very next cycle by a window access, which must already use the new block. The stimulus table issues these two accesses back to back with no idle cycle between them. It first fills the same offset in two different blocks with distinct words, so the read-back value shows which block was used. A simultaneous read and write, and a reset issued in the middle of the run, are added as directed cases.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
   typedef enum logic [2:0] {
      ACC_NONE    = 3'd0,
      ACC_WIN_RD  = 3'd1,
      ACC_WIN_WR  = 3'd2,
      ACC_SEL_RD  = 3'd3,
      ACC_SEL_WR  = 3'd4
   } acc_kind_e;
endpackage

// File: rtl/snoop_decode.sv
module snoop_decode
   import snoop_pkg::*;
#(
   parameter int          HADDR_W  = 12,
   parameter int          OFS_W    = 8,
   parameter logic [11:0] WIN_BASE = 12'h300,
   parameter logic [11:0] SEL_ADDR = 12'h2F0
) (
   input  logic [HADDR_W-1:0] addr,
   input  logic               rd,
   input  logic               wr,
   output acc_kind_e          kind,
   output logic               claim
);
   localparam int TAG_W = HADDR_W - OFS_W;

   initial assert (HADDR_W > OFS_W && HADDR_W <= 12);

   logic win_hit;
   logic sel_hit;

   assign win_hit = (addr[HADDR_W-1:OFS_W] == WIN_BASE[HADDR_W-1:OFS_W]);
   assign sel_hit = (addr == SEL_ADDR[HADDR_W-1:0]);
   assign claim   = win_hit | sel_hit;

   always_comb begin
      kind = ACC_NONE;
      if (win_hit) begin
         if (wr)      kind = ACC_WIN_WR;
         else if (rd) kind = ACC_WIN_RD;
      end else if (sel_hit) begin
         if (wr)      kind = ACC_SEL_WR;
         else if (rd) kind = ACC_SEL_RD;
      end
   end

   logic [TAG_W-1:0] unused_tag;
   assign unused_tag = addr[HADDR_W-1:OFS_W];
endmodule

// File: rtl/snoop_ptr_reg.sv
module snoop_ptr_reg #(
   parameter int              PTR_W  = 4,
   parameter int              DATA_W = 32,
   parameter logic [PTR_W-1:0] PTR_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [DATA_W-1:0] wdata,
   output logic [PTR_W-1:0]  ptr
);
   initial assert (PTR_W >= 1 && PTR_W <= DATA_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ptr <= PTR_RST;
      else if (ld) ptr <= wdata[PTR_W-1:0];
   end

   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(ptr));
endmodule

// File: rtl/snoop_rsp.sv
module snoop_rsp
   import snoop_pkg::*;
#(
   parameter int PTR_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_kind_e         kind,
   input  logic [PTR_W-1:0]  ptr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              ready,
   output logic [DATA_W-1:0] rdata
);
   logic              rdy_q;
   logic              win_rd_q;
   logic              sel_rd_q;
   logic [PTR_W-1:0]  ptr_cap_q;
   logic [DATA_W-1:0] ptr_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q     <= 1'b0;
         win_rd_q  <= 1'b0;
         sel_rd_q  <= 1'b0;
         ptr_cap_q <= '0;
      end else begin
         rdy_q    <= (kind != ACC_NONE);
         win_rd_q <= (kind == ACC_WIN_RD);
         sel_rd_q <= (kind == ACC_SEL_RD);
         if (kind == ACC_SEL_RD) ptr_cap_q <= ptr;
      end
   end

   generate
      if (DATA_W > PTR_W) begin : g_pad
         assign ptr_ext = {{(DATA_W-PTR_W){1'b0}}, ptr_cap_q};
      end else begin : g_full
         assign ptr_ext = ptr_cap_q;
      end
   endgenerate

   assign ready = rdy_q;
   assign rdata = sel_rd_q ? ptr_ext : (win_rd_q ? mem_rdata : '0);

   p_rdata_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (rdata == '0));
endmodule

// File: rtl/snoop_window_map.sv
module snoop_window_map
   import snoop_pkg::*;
#(
   parameter int          HADDR_W  = 12,
   parameter int          DATA_W   = 32,
   parameter int          WIN_SIZE = 256,
   parameter int          PTR_W    = 4,
   parameter logic [11:0] WIN_BASE = 12'h300,
   parameter logic [11:0] SEL_ADDR = 12'h2F0,
   localparam int         OFS_W    = $clog2(WIN_SIZE),
   localparam int         MADDR_W  = PTR_W + OFS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic               host_rd,
   input  logic               host_wr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic               host_ready,
   output logic               host_claim,
   output logic [MADDR_W-1:0] mem_addr,
   output logic               mem_re,
   output logic               mem_we,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata
);
   initial assert (WIN_SIZE == (1 << OFS_W));
   initial assert (WIN_BASE[OFS_W-1:0] == '0);

   acc_kind_e        kind;
   logic [PTR_W-1:0] ptr;

   snoop_decode #(
      .HADDR_W (HADDR_W),
      .OFS_W   (OFS_W),
      .WIN_BASE(WIN_BASE),
      .SEL_ADDR(SEL_ADDR)
   ) u_dec (
      .addr (host_addr),
      .rd   (host_rd),
      .wr   (host_wr),
      .kind (kind),
      .claim(host_claim)
   );

   snoop_ptr_reg #(
      .PTR_W (PTR_W),
      .DATA_W(DATA_W)
   ) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .ld   (kind == ACC_SEL_WR),
      .wdata(host_wdata),
      .ptr  (ptr)
   );

   snoop_rsp #(
      .PTR_W (PTR_W),
      .DATA_W(DATA_W)
   ) u_rsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .ptr      (ptr),
      .mem_rdata(mem_rdata),
      .ready    (host_ready),
      .rdata    (host_rdata)
   );

   assign mem_addr  = {ptr, host_addr[OFS_W-1:0]};
   assign mem_re    = (kind == ACC_WIN_RD);
   assign mem_we    = (kind == ACC_WIN_WR);
   assign mem_wdata = host_wdata;

   p_rw_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   p_wr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_claim && host_wr) |-> !mem_re);

   p_no_strobe_unclaimed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !host_claim |-> (!mem_re && !mem_we));

   p_ready_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> host_ready);

   p_ready_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> $past(host_claim && (host_rd || host_wr)));

   p_sel_no_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == SEL_ADDR[HADDR_W-1:0]) |-> (!mem_re && !mem_we));

   p_win_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re || mem_we) |=> (mem_addr[MADDR_W-1:OFS_W] == $past(mem_addr[MADDR_W-1:OFS_W])));
endmodule

// File: tb/snoop_window_map_tb_top.sv
module snoop_window_map_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] host_addr = '0;
   logic        host_rd = 1'b0;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_ready;
   logic        host_claim;
   logic [11:0] mem_addr;
   logic        mem_re;
   logic        mem_we;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   logic [3:0] ptr_model = '0;

   always #4 clk = ~clk;

   snoop_window_map dut_i (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_ready(host_ready), .host_claim(host_claim), .mem_addr(mem_addr),
      .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   logic [31:0] mem [4096];
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic        wr;
      logic        rd;
      logic [11:0] addr;
      logic [31:0] wd;
      logic        exp_rdy;
      logic [31:0] exp_rd;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b0, 12'h2F0, 32'h0000_0005, 1'b1, 32'h0},
      '{1'b1, 1'b0, 12'h300, 32'hA1A1_0001, 1'b1, 32'h0},
      '{1'b1, 1'b0, 12'h3FF, 32'hB2B2_0002, 1'b1, 32'h0},
      '{1'b1, 1'b0, 12'h2F0, 32'h0000_0009, 1'b1, 32'h0},
      '{1'b1, 1'b0, 12'h300, 32'hC3C3_0003, 1'b1, 32'h0},
      '{1'b0, 1'b1, 12'h300, 32'h0,         1'b1, 32'hC3C3_0003},
      '{1'b1, 1'b0, 12'h2F0, 32'h0000_0005, 1'b1, 32'h0},
      '{1'b0, 1'b1, 12'h300, 32'h0,         1'b1, 32'hA1A1_0001},
      '{1'b0, 1'b1, 12'h3FF, 32'h0,         1'b1, 32'hB2B2_0002},
      '{1'b0, 1'b1, 12'h2F0, 32'h0,         1'b1, 32'h0000_0005},
      '{1'b0, 1'b1, 12'h2FF, 32'h0,         1'b0, 32'h0},
      '{1'b1, 1'b0, 12'h400, 32'hDEAD_BEEF, 1'b0, 32'h0},
      '{1'b0, 1'b1, 12'h200, 32'h0,         1'b0, 32'h0},
      '{1'b1, 1'b0, 12'h2F0, 32'hFFFF_FFF3, 1'b1, 32'h0}
   };

   // One access: drive at the falling edge, look at strobes 1 ns later,
   // then read the response at the next falling edge.
   task automatic access(input logic wr, input logic rd, input logic [11:0] a,
                         input logic [31:0] wd, output logic claim, output logic re,
                         output logic we, output logic [11:0] ma, output logic rdy,
                         output logic [31:0] rdat);
      host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
      #1;
      claim = host_claim; re = mem_re; we = mem_we; ma = mem_addr;
      @(negedge clk);
      rdy = host_ready; rdat = host_rdata;
      host_wr = 1'b0; host_rd = 1'b0;
   endtask

   initial begin : watchdog
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic c, re, we, rdy;
      logic [11:0] ma;
      logic [31:0] rd;
      bit win, sel;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ready", {31'b0, host_ready}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      access(1'b0, 1'b1, 12'h2F0, 32'h0, c, re, we, ma, rdy, rd);
      chk("R1 ptr reset", rd, 32'h0);
      chk("R1 sel no mem", {30'b0, re, we}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         win = (VEC[i].addr[11:8] == 4'h3);
         sel = (VEC[i].addr == 12'h2F0);
         access(VEC[i].wr, VEC[i].rd, VEC[i].addr, VEC[i].wd, c, re, we, ma, rdy, rd);
         chk("R2 claim", {31'b0, c}, {31'b0, (win || sel)});
         if (win) begin
            chk("R3 mem_addr", {20'b0, ma}, {20'b0, ptr_model, VEC[i].addr[7:0]});
            chk("R4/R5 strobes", {30'b0, re, we}, {30'b0, VEC[i].rd, VEC[i].wr});
         end else begin
            chk("R2/R9 no strobe", {30'b0, re, we}, 32'h0);
         end
         chk("R4/R6 ready", {31'b0, rdy}, {31'b0, VEC[i].exp_rdy});
         chk("R4/R6/R7 rdata", rd, VEC[i].exp_rd);
         if (sel && VEC[i].wr) ptr_model = VEC[i].wd[3:0];
      end

      // R6 truncation read-back (pointer now 3)
      access(1'b0, 1'b1, 12'h2F0, 32'h0, c, re, we, ma, rdy, rd);
      chk("R6 truncated ptr", rd, 32'h3);

      // R5 physical placement of earlier writes
      chk("R5 blk5 ofs00", mem[12'h500], 32'hA1A1_0001);
      chk("R5 blk5 ofsFF", mem[12'h5FF], 32'hB2B2_0002);
      chk("R5 blk9 ofs00", mem[12'h900], 32'hC3C3_0003);

      // R8 read and write together: write wins
      access(1'b1, 1'b1, 12'h310, 32'h1234_5678, c, re, we, ma, rdy, rd);
      chk("R8 strobes", {30'b0, re, we}, 32'h1);
      chk("R8 rdata", rd, 32'h0);
      chk("R8 ready", {31'b0, rdy}, 32'h1);
      access(1'b0, 1'b1, 12'h310, 32'h0, c, re, we, ma, rdy, rd);
      chk("R8 readback", rd, 32'h1234_5678);
      chk("R9 ptr unchanged by window", {20'b0, ma}, 32'h310);

      // R1 reset in mid-run clears pointer
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 ready in reset", {31'b0, host_ready}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      access(1'b0, 1'b1, 12'h2F0, 32'h0, c, re, we, ma, rdy, rd);
      chk("R1 ptr after reset", rd, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule